// File: doc/BRIEF.md
# Round-Robin Scan Sequencer with End-of-Scan Gating

This block steps a logical-channel pointer through a round-robin list of up to eight channels. It advances one place each time an external converter reports a finished conversion. A 16-bit configuration word, written over a plain parallel port, sets three things: how many channels are in the list, whether the block is in low-power standby, and how the end-of-scan interrupt behaves. The interrupt fires when the last active channel of a pass completes.

After reset, and after each return from standby, the interrupt stays off for a warm-up. The warm-up is one full pass, or four full passes when line-noise rejection is enabled, so that downstream filtering can refill. A suppress option blocks the interrupt while any channel in the active list is flagged as calibrating. Calibration flags on channels outside the list have no effect.

Top module: `scan_seq_top`

## Requirements
- R1: After reset the configuration reads 0, the pointer is 0 (logical channel 1), `eos` is low and `scan_run` is high.
- R2: Configuration bits 15..13 always read as zero, whatever value is written to them.
- R3: The configuration field at bits 7..5 holds the channel count minus one (000 = 1 channel, 111 = 8). The pointer advances by one on each `conv_done` and returns to 0 after the last active channel.
- R4: While the standby bit (bit 3) is set, the pointer is held at 0, `eos` is low, `scan_run` is low and `conv_done` is ignored.
- R5: Entering or leaving standby does not change the configuration value read back.
- R6: Clearing the standby bit restarts scanning at logical channel 1: the pointer is 0, and the next `conv_done` moves it to 1.
- R7: After a restart, `eos` first asserts at the end of the fourth complete pass when bit 10 (line-noise rejection) is set, and at the end of the first complete pass when bit 10 is clear.
- R8: `eos` is a level that is set one cycle after the conversion that ends a pass. It stays high until `eos_ack` is pulsed or the next `conv_done` arrives, unless that conversion ends another pass.
- R9: When bit 11 (suppress) is set and any channel inside the active count has its `cal_flags` bit high at the end of a pass, `eos` does not assert for that pass.
- R10: `cal_flags` bits for channels at or beyond the active count have no effect on `eos`.
- R11: A change to the count field during a pass takes effect only once the current pass wraps.
- R12: The warm-up rule of R7 applies after reset just as it does after leaving standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration value |
| cal_flags | input | 8 | Per logical channel calibration-mode flags |
| conv_done | input | 1 | One-cycle strobe: conversion of the current channel finished |
| eos_ack | input | 1 | Host acknowledge, clears `eos` |
| chan_ptr | output | 3 | Current logical channel, 0-based |
| scan_run | output | 1 | High when not in standby |
| eos | output | 1 | End-of-scan interrupt level |

## Verification
A wrong pointer or a stale latched count shows up on `chan_ptr` within one `conv_done` of the fault, because every pass boundary is visible as a return to 0. A corrupted warm-up counter or a wrong suppress decision shows only at a pass boundary: `eos` rises one pass early or late, or rises when it should not. Those checks therefore sample `eos` on the cycle right after the conversion that ends each pass. Standby faults are visible at once on `scan_run`, `chan_ptr` and `eos` in the cycle after the bit is written.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
   localparam int CFG_W     = 16;
   localparam int RSV_LO    = 13;   // bits RSV_LO..CFG_W-1 are reserved, read zero
   localparam int SUP_BIT   = 11;   // block end-of-scan while an active channel calibrates
   localparam int LNR_BIT   = 10;   // line-noise rejection, lengthens warm-up
   localparam int CNT_LO    = 5;    // channel count minus one starts here
   localparam int SLEEP_BIT = 3;    // standby
endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg #(
   parameter int W      = 16,
   parameter int RSV_LO = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] keep_mask;

   generate
      if (RSV_LO < W) begin : g_rsv
         assign keep_mask = {{(W-RSV_LO){1'b0}}, {RSV_LO{1'b1}}};
      end else begin : g_norsv
         assign keep_mask = '1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & keep_mask;
   end
endmodule

// File: rtl/scan_chan_mask.sv
module scan_chan_mask #(
   parameter int N_CH = 8,
   localparam int CW  = $clog2(N_CH)
) (
   input  logic [CW-1:0]   last_idx,
   output logic [N_CH-1:0] mask
);
   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_bit
         assign mask[i] = (CW'(i) <= last_idx);
      end
   endgenerate
endmodule

// File: rtl/scan_pointer.sv
module scan_pointer #(
   parameter int N_CH = 8,
   localparam int CW  = $clog2(N_CH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep,
   input  logic          done,
   input  logic [CW-1:0] cnt_field,
   output logic [CW-1:0] ptr,
   output logic [CW-1:0] last_idx,
   output logic          scan_end
);
   assign scan_end = done && !sleep && (ptr == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         last_idx <= '0;
      end else if (sleep) begin
         ptr      <= '0;
         last_idx <= cnt_field;
      end else if (done) begin
         if (ptr == last_idx) begin
            ptr      <= '0;
            last_idx <= cnt_field;   // new count applies from the next pass
         end else begin
            ptr <= ptr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/scan_eos_ctl.sv
module scan_eos_ctl #(
   parameter int WARM_LNR   = 4,
   parameter int WARM_PLAIN = 1,
   localparam int WW        = $clog2(WARM_LNR + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic lnr,
   input  logic scan_end,
   input  logic done,
   input  logic suppress_hit,
   input  logic ack,
   output logic eos
);
   logic [WW-1:0] warm_q, warm_nx, need;

   assign need    = lnr ? WW'(WARM_LNR) : WW'(WARM_PLAIN);
   assign warm_nx = (warm_q == WW'(WARM_LNR)) ? warm_q : warm_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm_q <= '0;
         eos    <= 1'b0;
      end else if (sleep) begin
         warm_q <= '0;
         eos    <= 1'b0;
      end else begin
         if (scan_end) warm_q <= warm_nx;
         if (scan_end && (warm_nx >= need) && !suppress_hit) eos <= 1'b1;
         else if (ack || done)                               eos <= 1'b0;
      end
   end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
   import scan_seq_pkg::*;
#(
   parameter int N_CH       = 8,
   parameter int WARM_LNR   = 4,
   parameter int WARM_PLAIN = 1,
   localparam int CW        = $clog2(N_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic [N_CH-1:0]   cal_flags,
   input  logic              conv_done,
   input  logic              eos_ack,
   output logic [CW-1:0]     chan_ptr,
   output logic              scan_run,
   output logic              eos
);
   generate
      if (N_CH < 2 || (1 << CW) != N_CH) begin : g_bad_nch
         $error("N_CH must be a power of two of at least 2");
      end
      if (CNT_LO + CW > RSV_LO) begin : g_bad_field
         $error("count field overlaps reserved bits");
      end
      if (WARM_PLAIN < 1 || WARM_PLAIN > WARM_LNR) begin : g_bad_warm
         $error("warm-up counts out of order");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic [CW-1:0]    last_idx;
   logic [N_CH-1:0]  act_mask;
   logic             scan_end, sleep, suppress_hit;

   scan_cfg_reg #(.W(CFG_W), .RSV_LO(RSV_LO)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
   );

   assign sleep = cfg_q[SLEEP_BIT];

   scan_pointer #(.N_CH(N_CH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .done(conv_done),
      .cnt_field(cfg_q[CNT_LO +: CW]), .ptr(chan_ptr),
      .last_idx(last_idx), .scan_end(scan_end)
   );

   scan_chan_mask #(.N_CH(N_CH)) u_mask (
      .last_idx(last_idx), .mask(act_mask)
   );

   assign suppress_hit = cfg_q[SUP_BIT] && |(cal_flags & act_mask);

   scan_eos_ctl #(.WARM_LNR(WARM_LNR), .WARM_PLAIN(WARM_PLAIN)) u_eos (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .lnr(cfg_q[LNR_BIT]),
      .scan_end(scan_end), .done(conv_done), .suppress_hit(suppress_hit),
      .ack(eos_ack), .eos(eos)
   );

   assign cfg_rdata = cfg_q;
   assign scan_run  = !sleep;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [15:0]   cfg_rdata,
   input logic          conv_done,
   input logic          eos_ack,
   input logic [CW-1:0] chan_ptr,
   input logic          eos
);
   assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[15:13] == 3'b000);

   assert_sleep_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[3] |=> (chan_ptr == '0) && !eos);

   assert_ptr_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_done && !cfg_rdata[3]) |=> $stable(chan_ptr));

   assert_wake_ch1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_rdata[3]) |-> chan_ptr == '0);

   assert_eos_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eos && !eos_ack && !conv_done && !cfg_rdata[3]) |=> eos);

   assert_eos_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eos) |-> $past(conv_done));
endmodule

bind scan_seq_top scan_seq_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .conv_done(conv_done),
   .eos_ack(eos_ack), .chan_ptr(chan_ptr), .eos(eos)
);

// File: tb/scan_seq_top_tb.sv
module scan_seq_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic [7:0]  cal_flags = '0;
   logic        conv_done = 1'b0;
   logic        eos_ack = 1'b0;
   logic [2:0]  chan_ptr;
   logic        scan_run;
   logic        eos;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   scan_seq_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cal_flags(cal_flags), .conv_done(conv_done),
      .eos_ack(eos_ack), .chan_ptr(chan_ptr), .scan_run(scan_run), .eos(eos)
   );

   // {count field[2:0], pulses[7:0], expected ptr[2:0], expected eos}
   localparam logic [14:0] VEC [0:11] = '{
      {3'd0, 8'd1,  3'd0, 1'b1},
      {3'd0, 8'd3,  3'd0, 1'b1},
      {3'd1, 8'd1,  3'd1, 1'b0},
      {3'd1, 8'd2,  3'd0, 1'b1},
      {3'd2, 8'd5,  3'd2, 1'b0},
      {3'd3, 8'd4,  3'd0, 1'b1},
      {3'd4, 8'd7,  3'd2, 1'b0},
      {3'd7, 8'd8,  3'd0, 1'b1},
      {3'd7, 8'd7,  3'd7, 1'b0},
      {3'd7, 8'd16, 3'd0, 1'b1},
      {3'd5, 8'd9,  3'd3, 1'b0},
      {3'd6, 8'd14, 3'd0, 1'b1}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); conv_done = 1'b1;
         @(negedge clk); conv_done = 1'b0;
      end
   endtask

   // standby, then wake with the given value
   task automatic restart(input logic [15:0] v);
      wr(v | 16'h0008);
      wr(v);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 cfg", cfg_rdata, 16'h0000);
      check("R1 ptr", 16'(chan_ptr), 16'd0);
      check("R1 eos", 16'(eos), 16'd0);
      check("R1 run", 16'(scan_run), 16'd1);
      // R12 one pass of one channel after reset raises eos
      pulse(1);
      check("R12 eos after first pass", 16'(eos), 16'd1);

      // R3 R7 vector table, bit 10 clear
      for (int k = 0; k < 12; k++) begin
         restart({8'h00, VEC[k][14:12], 5'b00000});
         pulse(int'(VEC[k][11:4]));
         check("R3 ptr", 16'(chan_ptr), 16'(VEC[k][3:1]));
         check("R7 eos", 16'(eos), 16'(VEC[k][0]));
      end

      // R2 reserved bits
      wr(16'hFFFF);
      check("R2 readback", cfg_rdata, 16'h1FFF);
      wr(16'h0000);

      // R4 R5 standby
      restart(16'h0060);                   // 4 channels
      pulse(2);
      check("R3 ptr before standby", 16'(chan_ptr), 16'd2);
      wr(16'h0468);                        // standby, bit 10, count 4
      @(negedge clk);
      check("R4 ptr", 16'(chan_ptr), 16'd0);
      check("R4 run", 16'(scan_run), 16'd0);
      check("R4 eos", 16'(eos), 16'd0);
      pulse(3);
      check("R4 done ignored", 16'(chan_ptr), 16'd0);
      check("R5 cfg kept", cfg_rdata, 16'h0468);
      // R6 wake
      wr(16'h0460);
      check("R5 cfg after wake", cfg_rdata, 16'h0460);
      check("R6 ptr", 16'(chan_ptr), 16'd0);
      pulse(1);
      check("R6 next ptr", 16'(chan_ptr), 16'd1);
      // R7 four passes with bit 10 set (4 channels)
      pulse(3 + 4 * 2);
      check("R7 no eos after 3 passes", 16'(eos), 16'd0);
      pulse(4);
      check("R7 eos after 4 passes", 16'(eos), 16'd1);
      // R8 level held then acked
      repeat (3) @(negedge clk);
      check("R8 held", 16'(eos), 16'd1);
      eos_ack = 1'b1; @(negedge clk); eos_ack = 1'b0;
      check("R8 ack clears", 16'(eos), 16'd0);
      pulse(4);
      check("R8 set again", 16'(eos), 16'd1);
      pulse(1);
      check("R8 next done clears", 16'(eos), 16'd0);

      // R9 R10 suppression, 2 channels
      restart(16'h0820);
      cal_flags = 8'h02;
      pulse(2);
      check("R9 suppressed", 16'(eos), 16'd0);
      cal_flags = 8'h80;
      pulse(2);
      check("R10 inactive flag ignored", 16'(eos), 16'd1);
      cal_flags = 8'h00;

      // R11 count change mid pass
      restart(16'h0060);                   // 4 channels
      pulse(1);
      wr(16'h0000);                        // 1 channel, no standby
      pulse(2);
      check("R11 old count kept", 16'(chan_ptr), 16'd3);
      pulse(1);
      check("R11 wrap", 16'(chan_ptr), 16'd0);
      pulse(1);
      check("R11 new count", 16'(chan_ptr), 16'd0);
      check("R11 eos each pass", 16'(eos), 16'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule